// File: doc/BRIEF.md
# Glitch-Free Card Clock Selector

This block produces the clock pin of a smart-card interface. Three source clocks feed it: the system clock, a second internal clock and a clock arriving on an external pin. Each source can reach the pin undivided or divided down. A 3-bit select field picks one of eight combinations. Every divided version comes from a free-running counter in its own source domain, so a divided clock is always available and needs no phase alignment when it is picked.

A stop bit freezes the pin at a level held in a level bit. While stopped, software can drive the pin directly by toggling that level bit. Every change of select, stop or level reaches the pin without a runt pulse. The old source is released on one of its own low phases. The new source is admitted on one of its own low phases, and only after the old one is confirmed off. A handshake synchronised back into the system domain provides that confirmation.

The external-pin selections cannot be swapped with the internal ones while the pin is running. Such a request is ignored until the stop bit is set and the pin has actually stopped. A done output tells software when the requested configuration is truly in effect on the pin. The select, stop and level inputs are register bits synchronous to the system clock.

Top module: `card_clk_sel`

## Requirements
- R1: Select code values map as follows: 0 system clock, 1 second clock, 2 second clock / 2, 3 second clock / 4, 4 external pin clock, 5 external pin clock / 2, 6 system clock / 2, 7 system clock / 4. Each setting runs with a 50 % duty cycle when its source has one.
- R2: While rst_n is low, the pin and the done output are low and the accepted selection is 0. After reset is released with select 0 and stop clear, the pin runs from the undivided system clock.
- R3: While the stop bit is 1, the pin settles at the level bit's value (1 high, 0 low) and then shows no edges for as long as stop and level stay unchanged.
- R4: Across every change of select, stop or level, no high or low phase on the pin is shorter than half a period of the fastest source clock.
- R5: After a legal change, done rises within 64 system clock cycles, provided each source clock period is at most three system clock periods.
- R6: While stop is 0, a select change between the pin group (codes 4 and 5) and the internal group (all other codes) is ignored. The pin keeps the previous frequency, and done stays low.
- R7: A cross-group selection is taken over once stop is 1 and the pin has stopped. After stop is cleared, the pin runs from the new selection.
- R8: Done is high only when the pin reflects the current select, stop and level inputs. It is low while a change is pending or ignored.
- R9: While stopped, each change of the level bit appears on the pin, so software can drive the pin directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; also clocks the control inputs |
| clk_aux | input | 1 | Second internal source clock |
| clk_ext | input | 1 | Clock taken from an external pin |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 3 | Source and divider select code |
| stop_i | input | 1 | 1 freezes the pin at the level bit |
| level_i | input | 1 | Level held on the pin while stopped |
| card_clk_o | output | 1 | Card clock pin |
| cfg_done_o | output | 1 | Requested configuration is in effect on the pin |

## Verification
The main function is exercised in three ways. A directed walk visits all eight codes and measures the high and low phase of each against its own source period, so a swapped code or a wrong divider stands out. A seeded random walk mixes same-group changes, which switch on the fly, with cross-group changes, which force a stop with a random level. An edge monitor times every phase of the pin through all of these switches, so a runt pulse from a bad handshake is caught. A directed attempt to jump groups while running separates an ignored request from an accepted one: it checks that the frequency is unchanged and that done stays low until the stop bit is set.

// File: rtl/cksel_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the static map from select code to
// (source, divide ratio) for the card clock selector.
// Assumes three sources: index 0 system, 1 second clock, 2 external pin.
package cksel_pkg;

    localparam int NUM_SRC   = 3;
    localparam int NUM_LEGS  = 8;
    localparam int SEL_W     = $clog2(NUM_LEGS);

    // Source feeding a given select code.
    function automatic int leg_src(input int leg);
        case (leg)
            0, 6, 7: return 0;
            1, 2, 3: return 1;
            default: return 2;
        endcase
    endfunction

    // log2 of the divide ratio of a given select code.
    function automatic int leg_div_log2(input int leg);
        case (leg)
            0, 1, 4: return 0;
            2, 5, 6: return 1;
            default: return 2;
        endcase
    endfunction

    // Counter width a source needs to serve its deepest divider (min 1).
    function automatic int src_div_w(input int src);
        int w;
        w = 1;
        for (int i = 0; i < NUM_LEGS; i++) begin
            if (leg_src(i) == src && leg_div_log2(i) > w) begin
                w = leg_div_log2(i);
            end
        end
        return w;
    endfunction

    // True for the codes fed from the external pin clock.
    function automatic logic is_pin_group(input logic [SEL_W-1:0] code);
        return (code == SEL_W'(4)) || (code == SEL_W'(5));
    endfunction

endpackage

// File: rtl/cksel_div.sv
`timescale 1ns/1ps
// Module: free-running ripple-free binary counter in one source domain.
// Bit k toggles at 1/2^(k+1) of the source rate, giving /2, /4 clocks.
// Assumes rst_n is held long enough to span a few source periods.
module cksel_div #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] div_o
);

    logic [STAGES-1:0] cnt_q;

    // Advance the divider counter on every source rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign div_o = cnt_q;

endmodule

// File: rtl/cksel_leg.sv
`timescale 1ns/1ps
// Module: one gated input of the clock mux.
// The request from the system domain is captured on a falling edge of the
// base clock, and the enable only changes while the leg clock is low, so
// the gated output never carries a shortened phase.
// Assumes leg_clk changes only on base_clk rising edges (or is base_clk).
module cksel_leg (
    input  logic base_clk,
    input  logic rst_n,
    input  logic leg_clk,
    input  logic want_i,
    output logic gclk_o,
    output logic en_o
);

    logic req_q;
    logic en_q;

    // First synchroniser stage for the request crossing into this domain.
    always_ff @(negedge base_clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= want_i;
        end
    end

    // Second stage doubling as the gate enable, moved only in a low phase.
    always_ff @(negedge base_clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (!leg_clk) begin
            en_q <= req_q;
        end
    end

    assign gclk_o = leg_clk & en_q;
    assign en_o   = en_q;

endmodule

// File: rtl/cksel_ctrl.sv
`timescale 1ns/1ps
// Module: system-domain sequencer for the card clock selector.
// Accepts select changes (cross-group only while stopped and quiet), runs a
// four-phase handshake with each leg so at most one leg is ever enabled,
// owns the stopped-level driver and reports when the pin matches the request.
// Assumes sel_i, stop_i, level_i are synchronous to clk.
module cksel_ctrl #(
    parameter int LEGS   = 8,
    parameter int SW     = 3,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   sel_i,
    input  logic            stop_i,
    input  logic            level_i,
    input  logic [LEGS-1:0] leg_en_i,
    output logic [LEGS-1:0] want_o,
    output logic [LEGS-1:0] en_seen_o,
    output logic            lvl_o,
    output logic [SW-1:0]   acc_sel_o,
    output logic            done_o
);
    import cksel_pkg::*;

    logic [LEGS-1:0] sync_q [STAGES];
    logic [LEGS-1:0] en_seen;
    logic [LEGS-1:0] want_q, want_nxt;
    logic [LEGS-1:0] hold_v, fresh_v;
    logic [SW-1:0]   acc_q;
    logic            lvl_q, lvl_nxt;
    logic            done_q, done_nxt;
    logic            all_off, accept;

    // Bring the leg enables back into the system domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                sync_q[k] <= '0;
            end
        end else begin
            sync_q[0] <= leg_en_i;
            for (int k = 1; k < STAGES; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
        end
    end

    assign en_seen = sync_q[STAGES-1];
    assign all_off = (en_seen == '0);
    assign accept  = (is_pin_group(sel_i) == is_pin_group(acc_q)) || (stop_i && all_off);

    // Decide per leg whether its request is held or newly raised.
    always_comb begin
        for (int i = 0; i < LEGS; i++) begin
            hold_v[i]  = want_q[i] && !en_seen[i];
            fresh_v[i] = !stop_i && !lvl_q && (acc_q == SW'(i)) &&
                         (((en_seen | want_q) & ~(LEGS'(1) << i)) == '0);
        end
        want_nxt = hold_v | fresh_v;
    end

    // Stopped-level driver may only rise once every leg is quiet.
    assign lvl_nxt = stop_i && level_i && all_off && (want_q == '0);

    // Done compares the pin state now in force with the live request.
    always_comb begin
        if (stop_i) begin
            done_nxt = all_off && (want_q == '0) && (lvl_q == level_i) && (acc_q == sel_i);
        end else begin
            done_nxt = !lvl_q && (acc_q == sel_i) && (en_seen == (LEGS'(1) << acc_q));
        end
    end

    // Register the accepted selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (accept) begin
            acc_q <= sel_i;
        end
    end

    // Register requests, the level driver and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q <= '0;
            lvl_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            want_q <= want_nxt;
            lvl_q  <= lvl_nxt;
            done_q <= done_nxt;
        end
    end

    assign want_o    = want_q;
    assign en_seen_o = en_seen;
    assign lvl_o     = lvl_q;
    assign acc_sel_o = acc_q;
    assign done_o    = done_q;

endmodule

// File: rtl/card_clk_sel.sv
`timescale 1ns/1ps
// Module: top of the card clock selector.
// Builds one divider per source, one gated leg per select code and the
// system-domain sequencer; the pin is the OR of all gated legs and the
// stopped-level driver, of which at most one is ever active.
// Assumes rst_n spans several periods of every source clock.
module card_clk_sel
    import cksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_sys,
    input  logic             clk_aux,
    input  logic             clk_ext,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             stop_i,
    input  logic             level_i,
    output logic             card_clk_o,
    output logic             cfg_done_o
);

    logic [NUM_SRC-1:0]  src_clk;
    logic [NUM_LEGS-1:0] leg_clk;
    logic [NUM_LEGS-1:0] want;
    logic [NUM_LEGS-1:0] leg_en;
    logic [NUM_LEGS-1:0] gclk;
    logic [NUM_LEGS-1:0] en_seen;
    logic                lvl_q;
    logic [SEL_W-1:0]    acc_sel;

    assign src_clk = {clk_ext, clk_aux, clk_sys};

    // One divider per source; wire each select code to its leg clock.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int DW = src_div_w(s);
        logic [DW-1:0] div;

        cksel_div #(.STAGES(DW)) u_div (
            .clk   (src_clk[s]),
            .rst_n (rst_n),
            .div_o (div)
        );

        for (genvar i = 0; i < NUM_LEGS; i++) begin : g_map
            if (leg_src(i) == s) begin : g_own
                if (leg_div_log2(i) == 0) begin : g_direct
                    assign leg_clk[i] = src_clk[s];
                end else begin : g_divided
                    assign leg_clk[i] = div[leg_div_log2(i)-1];
                end
            end
        end
    end

    // One gated leg per select code, clocked by its own source.
    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
        cksel_leg u_leg (
            .base_clk (src_clk[leg_src(i)]),
            .rst_n    (rst_n),
            .leg_clk  (leg_clk[i]),
            .want_i   (want[i]),
            .gclk_o   (gclk[i]),
            .en_o     (leg_en[i])
        );
    end

    cksel_ctrl #(
        .LEGS   (NUM_LEGS),
        .SW     (SEL_W),
        .STAGES (SYNC_STAGES)
    ) u_ctrl (
        .clk       (clk_sys),
        .rst_n     (rst_n),
        .sel_i     (sel_i),
        .stop_i    (stop_i),
        .level_i   (level_i),
        .leg_en_i  (leg_en),
        .want_o    (want),
        .en_seen_o (en_seen),
        .lvl_o     (lvl_q),
        .acc_sel_o (acc_sel),
        .done_o    (cfg_done_o)
    );

    assign card_clk_o = (|gclk) | lvl_q;

endmodule

// File: rtl/card_clk_sel_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound into card_clk_sel; observes the
// sequencer's requests, returned enables and accepted selection.
module card_clk_sel_chk
    import cksel_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                stop,
    input logic [SEL_W-1:0]    sel,
    input logic [SEL_W-1:0]    acc,
    input logic [NUM_LEGS-1:0] want,
    input logic [NUM_LEGS-1:0] en_seen,
    input logic                lvl,
    input logic                done
);

    assert_reset_sel_R2: assert property (@(posedge clk)
        !rst_n |=> (acc == '0));

    assert_one_leg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_seen) && $onehot0(want));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (want != '0) |-> ((en_seen & ~want) == '0));

    assert_level_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl |-> ((want == '0) && (en_seen == '0)));

    assert_cross_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (is_pin_group(acc) != is_pin_group($past(acc)))) |-> $past(stop));

    assert_done_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc == $past(sel)));

endmodule

bind card_clk_sel card_clk_sel_chk u_chk (
    .clk     (clk_sys),
    .rst_n   (rst_n),
    .stop    (stop_i),
    .sel     (sel_i),
    .acc     (acc_sel),
    .want    (want),
    .en_seen (en_seen),
    .lvl     (lvl_q),
    .done    (cfg_done_o)
);

// File: tb/card_clk_sel_tb.sv
`timescale 1ns/1ps
// Bench: directed walk, illegal cross-group attempt and a seeded random walk,
// checking phase widths, stop levels and done timing against bench models.
module card_clk_sel_tb;

    localparam real SYS_P = 4.0;
    localparam real AUX_P = 6.0;
    localparam real EXT_P = 10.0;
    localparam real MIN_PHASE = 1.9;

    logic       clk_sys = 1'b0, clk_aux = 1'b0, clk_ext = 1'b0, rst_n = 1'b0;
    logic [2:0] sel_r = 3'd0;
    logic       stop_r = 1'b0, level_r = 1'b0;
    logic       card_clk, done;

    int  checks = 0, errors = 0, edge_cnt = 0, narrow_cnt = 0, cur_sel = 0;
    bit  mon_on = 1'b0;
    realtime last_edge = 0;

    always #(SYS_P/2) clk_sys = ~clk_sys;
    always #(AUX_P/2) clk_aux = ~clk_aux;
    always #(EXT_P/2) clk_ext = ~clk_ext;

    card_clk_sel u_dut (
        .clk_sys    (clk_sys),
        .clk_aux    (clk_aux),
        .clk_ext    (clk_ext),
        .rst_n      (rst_n),
        .sel_i      (sel_r),
        .stop_i     (stop_r),
        .level_i    (level_r),
        .card_clk_o (card_clk),
        .cfg_done_o (done)
    );

    // Time every pin phase and count edges.
    always @(card_clk) begin
        if (mon_on) begin
            if ($realtime - last_edge < MIN_PHASE) narrow_cnt++;
            edge_cnt++;
        end
        last_edge = $realtime;
    end

    function automatic real exp_half(input int s);
        real p;
        case (s)
            0, 6, 7: p = SYS_P;
            1, 2, 3: p = AUX_P;
            default: p = EXT_P;
        endcase
        case (s)
            2, 5, 6: p = p * 2.0;
            3, 7:    p = p * 4.0;
            default: ;
        endcase
        return p / 2.0;
    endfunction

    function automatic bit pin_grp(input int s);
        return (s == 4) || (s == 5);
    endfunction

    function automatic real rdiff(input real a, input real b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
        end
    endtask

    task automatic drive(input int s, input bit st, input bit lv);
        @(negedge clk_sys);
        sel_r   = 3'(s);
        stop_r  = st;
        level_r = lv;
    endtask

    task automatic wait_done(output int cyc);
        bit seen;
        seen = 1'b0;
        cyc  = 0;
        while (!seen && cyc < 300) begin
            @(posedge clk_sys);
            #1;
            if (done) seen = 1'b1;
            else cyc++;
        end
    endtask

    task automatic check_freq(input int s, input string req);
        realtime t0, t1, t2;
        @(posedge card_clk);
        @(posedge card_clk); t0 = $realtime;
        @(negedge card_clk); t1 = $realtime;
        @(posedge card_clk); t2 = $realtime;
        chk(rdiff(t1 - t0, exp_half(s)) < 0.05, req, $sformatf("high phase sel=%0d", s), t1 - t0, exp_half(s));
        chk(rdiff(t2 - t1, exp_half(s)) < 0.05, req, $sformatf("low phase sel=%0d", s), t2 - t1, exp_half(s));
    endtask

    // Move to a new selection by the legal path, checking along the way.
    task automatic go_to(input int s);
        int  c, e0;
        bit  lv;
        if (pin_grp(s) != pin_grp(cur_sel)) begin
            lv = 1'($urandom % 2);
            drive(cur_sel, 1'b1, lv);
            wait_done(c);
            chk(c <= 64, "R5", "stop latency", c, 64);
            e0 = edge_cnt;
            repeat (30) @(posedge clk_sys);
            #1;
            chk(card_clk == lv && edge_cnt == e0, "R3", "stopped pin level/edges", card_clk, lv);
            drive(cur_sel, 1'b1, !lv);
            wait_done(c);
            chk(card_clk == !lv, "R9", "software level drive", card_clk, !lv);
            drive(s, 1'b1, !lv);
            wait_done(c);
            chk(done && card_clk == !lv, "R7", "cross-group taken while stopped", done, 1);
            drive(s, 1'b0, !lv);
            wait_done(c);
            chk(c <= 64, "R5", "restart latency", c, 64);
            check_freq(s, "R7");
        end else begin
            drive(s, 1'b0, level_r);
            wait_done(c);
            chk(c <= 64, "R5", "same-group switch latency", c, 64);
        end
        check_freq(s, "R1");
        cur_sel = s;
    endtask

    initial begin
        int c;
        void'($urandom(32'h00C0FFEE));
        repeat (20) @(posedge clk_sys);
        #1;
        chk(card_clk == 1'b0, "R2", "pin in reset", card_clk, 0);
        chk(done == 1'b0, "R2", "done in reset", done, 0);
        @(negedge clk_sys);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        wait_done(c);
        chk(c <= 64, "R5", "first lock latency", c, 64);
        check_freq(0, "R2");

        // Directed walk over every code.
        for (int s = 1; s < 8; s++) go_to(s);
        go_to(1);

        // Illegal cross-group switch while running: ignored.
        drive(4, 1'b0, 1'b0);
        repeat (80) @(posedge clk_sys);
        #1;
        chk(done == 1'b0, "R6 R8", "done during ignored request", done, 0);
        check_freq(1, "R6");
        drive(4, 1'b1, 1'b1);
        wait_done(c);
        chk(card_clk == 1'b1, "R7", "pin high once stopped", card_clk, 1);
        drive(4, 1'b0, 1'b1);
        wait_done(c);
        check_freq(4, "R7");
        cur_sel = 4;

        // Seeded random walk.
        for (int n = 0; n < 30; n++) go_to(int'($urandom % 8));

        // Stop low at the end.
        drive(cur_sel, 1'b1, 1'b0);
        wait_done(c);
        repeat (10) @(posedge clk_sys);
        #1;
        chk(card_clk == 1'b0, "R3", "stopped low", card_clk, 0);
        chk(narrow_cnt == 0, "R4", "runt phases", narrow_cnt, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * SYS_P);
        errors++;
        $display("FAIL R5 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule